// File: doc/BRIEF.md
# Frequency-Select Watchdog Recovery Controller

This block decides which five-bit frequency-select code drives a clock synthesizer. It also guards the system against a hang that follows an unsafe frequency change. While the power-good input is low, the strap inputs are sampled. Once power-good goes high, the sampled code is frozen and stays readable. Software can override the strapped code with its own select field, or it can hand the frequency over to direct divider (M/N) programming.

A programmable watchdog counts down in units of one tick. One tick stands for 250 ms, and a prescaler derives it from the system clock. If software does not stop or restart the watchdog before the count runs out, the block does four things:

- It drives an open-drain reset output low for one tick.
- It cancels M/N programming.
- It loads a recovery code into the software select field and turns the override on. The recovery code is either a programmed safe code or the latched strap code.
- It raises a sticky timeout flag.

Software writes through a four-address configuration port. Status comes back on dedicated outputs.

Top module: `fsel_wdog_ctrl`

## Requirements
- R1: While `pwr_good` is 0, `strap_latched` follows `strap_in`, one clock later. While `pwr_good` is 1, `strap_latched` holds its value.
- R2: A write to address 0 sets the software code from data[4:0], the override enable from data[5] and the safe-recovery enable from data[6]. One clock after the write, `fs_active` equals the software code when the override is 1, and `strap_latched` when it is 0.
- R3: A write to address 3 sets the M/N programming enable from data[7]. The enable is visible on `mn_active` right after the write edge.
- R4: A write to address 2 sets the watchdog depth from data[6:0].
- R5: A write to address 1 always stores data[4:0] as the safe code. When data[6] is 1, it starts or restarts the watchdog: the count is reloaded from the depth, `wd_running` becomes 1 and `wd_timeout` is cleared. While the watchdog runs, `wd_count` shows the remaining count. That count drops by one every TICK_CYCLES clocks after the start edge. While the watchdog is idle, `wd_count` shows the depth.
- R6: When data[6] is 0, a write to address 1 stops a running watchdog. Stopping it causes no reset pulse and no timeout.
- R7: Expiry happens on the clock edge on which the count would reach zero. At that edge `wd_running` falls and `wd_timeout` rises. `wd_timeout` stays at 1 until the next start. `wd_running` and `wd_timeout` are never both 1.
- R8: From the expiry edge on, `rst_drive_low` is 1 for exactly TICK_CYCLES clocks.
- R9: At expiry, the M/N enable is cleared and the override enable is set. The software code is loaded with the safe code when safe-recovery is 1, and with `strap_latched` when it is 0.
- R10: After a synchronous reset, the following values hold: depth 8, safe code 5'b00010, all enables 0, software code 0, watchdog idle, timeout 0, and `rst_drive_low` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_good | input | 1 | Power-good level; straps are sampled while it is low |
| strap_in | input | 5 | Frequency-select strap inputs |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration address (0 select, 1 watchdog, 2 depth, 3 M/N) |
| cfg_wdata | input | 8 | Configuration write data |
| strap_latched | output | 5 | Latched strap code |
| fs_active | output | 5 | Registered active frequency-select code |
| sw_code | output | 5 | Software select field |
| sw_en | output | 1 | Software override enable |
| mn_active | output | 1 | Direct M/N programming enable |
| wd_running | output | 1 | Watchdog counting |
| wd_timeout | output | 1 | Sticky expiry flag |
| wd_count | output | 7 | Remaining count while running, depth while idle |
| rst_drive_low | output | 1 | 1 pulls the open-drain reset pin low |

## Verification
The results fall due at different times after a configuration write:
- `sw_code`, `sw_en`, `mn_active` and the watchdog flags change on the write edge itself.
- `fs_active` changes one edge later.
- Watchdog events fall on whole multiples of TICK_CYCLES edges after the start edge.
- The reset pulse ends TICK_CYCLES edges after expiry.

The bench drives inputs on the falling edge and samples on the falling edge. It counts rising edges from each start write and checks the count, the flags and the pulse one edge before each due cycle and again at it. This way an off-by-one in the prescaler or in the pulse length shows up as a mismatch.

// File: rtl/fsel_pkg.sv
package fsel_pkg;
  localparam int FS_W    = 5;
  localparam int DEPTH_W = 7;

  typedef enum logic [1:0] {
    CFG_SELECT = 2'd0,
    CFG_WDOG   = 2'd1,
    CFG_DEPTH  = 2'd2,
    CFG_MN     = 2'd3
  } cfg_addr_e;

  localparam logic [FS_W-1:0]    SAFE_RESET  = 5'b00010;
  localparam logic [DEPTH_W-1:0] DEPTH_RESET = 7'd8;
endpackage

// File: rtl/fsel_strap_latch.sv
module fsel_strap_latch #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         pwr_good,
  input  logic [W-1:0] strap_in,
  output logic [W-1:0] strap_q
);
  always_ff @(posedge clk) begin
    if (rst)
      strap_q <= '0;
    else if (!pwr_good)
      strap_q <= strap_in;
  end
endmodule

// File: rtl/fsel_tick_gen.sv
module fsel_tick_gen #(
  parameter int TICK_CYCLES = 25_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic clear,
  output logic tick
);
  localparam int PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_CYCLES - 1);

  logic [PW-1:0] pre;

  always_ff @(posedge clk) begin
    if (rst || clear)
      pre <= '0;
    else if (run)
      pre <= (pre == LAST) ? '0 : pre + 1'b1;
  end

  assign tick = run && (pre == LAST);
endmodule

// File: rtl/fsel_wdog_core.sv
module fsel_wdog_core #(
  parameter int DEPTH_W    = 7,
  parameter int RST_CYCLES = 25_000_000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               stop,
  input  logic               tick,
  input  logic [DEPTH_W-1:0] depth,
  output logic               running,
  output logic               timeout,
  output logic [DEPTH_W-1:0] remain,
  output logic               expire,
  output logic               rst_low
);
  localparam int CW = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
  localparam logic [CW-1:0] PULSE_LAST = CW'(RST_CYCLES - 1);

  logic [CW-1:0] pcnt;

  assign expire = running && tick && (remain <= DEPTH_W'(1)) && !start && !stop;

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      timeout <= 1'b0;
      remain  <= '0;
    end else if (start) begin
      running <= 1'b1;
      timeout <= 1'b0;
      remain  <= depth;
    end else if (stop) begin
      running <= 1'b0;
    end else if (expire) begin
      running <= 1'b0;
      timeout <= 1'b1;
      remain  <= '0;
    end else if (running && tick) begin
      remain  <= remain - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_low <= 1'b0;
      pcnt    <= '0;
    end else if (expire) begin
      rst_low <= 1'b1;
      pcnt    <= PULSE_LAST;
    end else if (rst_low) begin
      if (pcnt == '0)
        rst_low <= 1'b0;
      else
        pcnt <= pcnt - 1'b1;
    end
  end
endmodule

// File: rtl/fsel_wdog_ctrl.sv
module fsel_wdog_ctrl #(
  parameter int TICK_CYCLES = 25_000_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pwr_good,
  input  logic [4:0] strap_in,
  input  logic       cfg_wr,
  input  logic [1:0] cfg_addr,
  input  logic [7:0] cfg_wdata,
  output logic [4:0] strap_latched,
  output logic [4:0] fs_active,
  output logic [4:0] sw_code,
  output logic       sw_en,
  output logic       mn_active,
  output logic       wd_running,
  output logic       wd_timeout,
  output logic [6:0] wd_count,
  output logic       rst_drive_low
);
  import fsel_pkg::*;

  logic               safe_en;
  logic [FS_W-1:0]    safe_code;
  logic [DEPTH_W-1:0] depth;
  logic [DEPTH_W-1:0] remain;
  logic               wr_sel, wr_wdog, wr_depth, wr_mn;
  logic               start, stop, tick, expire;

  assign wr_sel   = cfg_wr && (cfg_addr_e'(cfg_addr) == CFG_SELECT);
  assign wr_wdog  = cfg_wr && (cfg_addr_e'(cfg_addr) == CFG_WDOG);
  assign wr_depth = cfg_wr && (cfg_addr_e'(cfg_addr) == CFG_DEPTH);
  assign wr_mn    = cfg_wr && (cfg_addr_e'(cfg_addr) == CFG_MN);
  assign start    = wr_wdog && cfg_wdata[6];
  assign stop     = wr_wdog && !cfg_wdata[6];

  fsel_strap_latch #(.W(FS_W)) u_strap (
    .clk(clk), .rst(rst), .pwr_good(pwr_good),
    .strap_in(strap_in), .strap_q(strap_latched)
  );

  fsel_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk(clk), .rst(rst), .run(wd_running), .clear(start), .tick(tick)
  );

  fsel_wdog_core #(.DEPTH_W(DEPTH_W), .RST_CYCLES(TICK_CYCLES)) u_core (
    .clk(clk), .rst(rst), .start(start), .stop(stop), .tick(tick),
    .depth(depth), .running(wd_running), .timeout(wd_timeout),
    .remain(remain), .expire(expire), .rst_low(rst_drive_low)
  );

  // configuration fields; recovery on expiry overrides software writes
  always_ff @(posedge clk) begin
    if (rst) begin
      sw_code   <= '0;
      sw_en     <= 1'b0;
      safe_en   <= 1'b0;
      safe_code <= SAFE_RESET;
      depth     <= DEPTH_RESET;
      mn_active <= 1'b0;
    end else begin
      if (wr_wdog)  safe_code <= cfg_wdata[4:0];
      if (wr_depth) depth     <= cfg_wdata[6:0];
      if (expire) begin
        sw_code   <= safe_en ? safe_code : strap_latched;
        sw_en     <= 1'b1;
        mn_active <= 1'b0;
      end else begin
        if (wr_sel) begin
          sw_code <= cfg_wdata[4:0];
          sw_en   <= cfg_wdata[5];
        end
        if (wr_mn) mn_active <= cfg_wdata[7];
      end
      if (wr_sel) safe_en <= cfg_wdata[6];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      fs_active <= '0;
    else
      fs_active <= sw_en ? sw_code : strap_latched;
  end

  assign wd_count = wd_running ? remain : depth;
endmodule

// File: rtl/fsel_wdog_chk.sv
module fsel_wdog_chk (
  input logic       clk,
  input logic       rst,
  input logic       pwr_good,
  input logic       cfg_wr,
  input logic [4:0] strap_latched,
  input logic       mn_active,
  input logic       wd_running,
  input logic       wd_timeout,
  input logic [6:0] wd_count,
  input logic       rst_drive_low
);
  // R1: frozen strap code while power-good stays high
  a_r1_strap_hold: assert property (@(posedge clk) disable iff (rst)
    (pwr_good && $past(pwr_good) && !$past(rst)) |-> $stable(strap_latched));

  // R5: the remaining count never climbs without a write
  a_r5_count_down: assert property (@(posedge clk) disable iff (rst)
    (wd_running && $past(wd_running) && !$past(cfg_wr) && !$past(rst))
      |-> (wd_count <= $past(wd_count)));

  // R7: running and timeout are exclusive
  a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(wd_running && wd_timeout));

  // R8: a reset pulse only starts together with a timeout
  a_r8_pulse_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_drive_low) |-> wd_timeout);

  // R9: expiry cancels M/N programming
  a_r9_mn_cleared: assert property (@(posedge clk) disable iff (rst)
    $rose(wd_timeout) |-> !mn_active);
endmodule

bind fsel_wdog_ctrl fsel_wdog_chk u_chk (
  .clk(clk), .rst(rst), .pwr_good(pwr_good), .cfg_wr(cfg_wr),
  .strap_latched(strap_latched), .mn_active(mn_active),
  .wd_running(wd_running), .wd_timeout(wd_timeout),
  .wd_count(wd_count), .rst_drive_low(rst_drive_low)
);

// File: tb/fsel_wdog_ctrl_bench.sv
module fsel_wdog_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TICK = 8;
  localparam logic [4:0] STRAP_A = 5'b01011;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pwr_good = 1'b0;
  logic [4:0] strap_in = STRAP_A;
  logic       cfg_wr = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [4:0] strap_latched, fs_active, sw_code;
  logic       sw_en, mn_active, wd_running, wd_timeout, rst_drive_low;
  logic [6:0] wd_count;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fsel_wdog_ctrl #(.TICK_CYCLES(TICK)) u_fsel_wdog_ctrl (
    .clk(clk), .rst(rst), .pwr_good(pwr_good), .strap_in(strap_in),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .strap_latched(strap_latched), .fs_active(fs_active), .sw_code(sw_code),
    .sw_en(sw_en), .mn_active(mn_active), .wd_running(wd_running),
    .wd_timeout(wd_timeout), .wd_count(wd_count), .rst_drive_low(rst_drive_low)
  );

  function automatic logic [4:0] exp_active(input logic en, input logic [4:0] code,
                                            input logic [4:0] strap);
    return en ? code : strap;
  endfunction

  function automatic int exp_count(input int depth, input int edges);
    return depth - edges / TICK;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired in bench");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [4:0] code;
    logic       en;
    void'($urandom(32'd2718));
    wait_edges(3);
    rst = 1'b0;
    wait_edges(2);
    // R10 reset state
    chk("R10 depth", wd_count, 8);
    chk("R10 running", wd_running, 0);
    chk("R10 timeout", wd_timeout, 0);
    chk("R10 rst_low", rst_drive_low, 0);
    chk("R10 mn", mn_active, 0);
    chk("R10 sw_en", sw_en, 0);
    // R1 strap latching
    chk("R1 follow", strap_latched, STRAP_A);
    pwr_good = 1'b1;
    wait_edges(1);
    strap_in = 5'b10100;
    wait_edges(3);
    chk("R1 hold", strap_latched, STRAP_A);
    chk("R2 strap path", fs_active, STRAP_A);

    // R2 random override patterns
    for (int i = 0; i < 40; i++) begin
      code = 5'($urandom);
      en   = 1'($urandom);
      wr(2'd0, {2'b00, en, code});
      wait_edges(1);
      chk("R2 active", fs_active, exp_active(en, code, STRAP_A));
    end

    // R3 M/N enable
    wr(2'd3, 8'h80);
    chk("R3 set", mn_active, 1);
    wr(2'd3, 8'h00);
    chk("R3 clear", mn_active, 0);

    // R4/R5/R7/R8/R9 expiry with safe recovery
    wr(2'd0, 8'b0100_0101);          // safe_en=1, override off, code 5
    wr(2'd3, 8'h80);
    wr(2'd2, 8'd3);                  // R4 depth 3
    chk("R4 depth", wd_count, 3);
    wr(2'd1, 8'b0101_1001);          // start, safe code 25
    chk("R5 start", wd_running, 1);
    wait_edges(TICK + 1);
    chk("R5 count", wd_count, exp_count(3, TICK + 1));
    wait_edges(3 * TICK - TICK - 2); // total 3*TICK-1 edges
    chk("R7 before expiry", wd_timeout, 0);
    chk("R8 before expiry", rst_drive_low, 0);
    wait_edges(1);
    chk("R7 running fell", wd_running, 0);
    chk("R7 timeout", wd_timeout, 1);
    chk("R8 pulse on", rst_drive_low, 1);
    chk("R9 mn cleared", mn_active, 0);
    chk("R9 safe loaded", sw_code, 25);
    chk("R9 override set", sw_en, 1);
    wait_edges(1);
    chk("R9 active", fs_active, 25);
    wait_edges(TICK - 2);
    chk("R8 pulse last", rst_drive_low, 1);
    wait_edges(1);
    chk("R8 pulse end", rst_drive_low, 0);
    chk("R7 sticky", wd_timeout, 1);

    // R9 strap recovery
    wr(2'd0, 8'b0000_0111);          // safe_en=0
    wr(2'd2, 8'd1);
    wr(2'd1, 8'b0100_0000);
    chk("R5 restart clears timeout", wd_timeout, 0);
    wait_edges(TICK);
    chk("R7 expiry depth1", wd_timeout, 1);
    chk("R9 strap loaded", sw_code, STRAP_A);

    // R5 restart reload, R6 stop
    wr(2'd2, 8'd2);
    wr(2'd1, 8'b0100_0000);
    wait_edges(TICK + 2);
    chk("R5 mid count", wd_count, 1);
    wr(2'd1, 8'b0100_0000);
    chk("R5 reload", wd_count, 2);
    wait_edges(3);
    wr(2'd1, 8'b0000_0000);
    chk("R6 stopped", wd_running, 0);
    wait_edges(3 * TICK);
    chk("R6 no timeout", wd_timeout, 0);
    chk("R6 no pulse", rst_drive_low, 0);
    chk("R5 idle shows depth", wd_count, 2);

    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule